// File: doc/BRIEF.md
# Five-Decade BCD Event Counter

This block counts rising edges of an asynchronous event line. It holds the count as five cascaded decimal digits, from units up to ten-thousands. The event line is brought into the system clock domain by a two-flop synchronizer. A rising-edge detector then turns each low-to-high change into a one-cycle count strobe. Every digit is an ordinary synchronous register, and a decade steps on the strobe when the stage feeding it carries.

A two-bit mode input changes the role of the units decade:
- It can be a plain fifth digit.
- It can be a hidden prescaler that passes a carry at its 4-to-5 step, which rounds to the nearest ten.
- It can be a half-unit digit that reads 5 or 0 and carries at its 7-to-8 step.
- In the test mode, the event strobe drives several decades at once, so that high counts are reached quickly.

A carry-out flag marks a roll-over of the top decade, for cascading into a further counter. A synchronous master clear empties every decade.

Top module: `bcd_evt_counter`

## Requirements
- R1: While `rst_n` is low, all digits read 0 and `carry_out` is 0.
- R2: Each rising transition of `count_in` produces exactly one count event. A level held high or low produces none. `count_in` must stay at each level for at least two clock cycles. The digits change at the third rising `clk` edge after `count_in` rises.
- R3: With `mode_sel` = 2'b00, the block is a five-digit decimal counter. Digit i appears on `digit_out[4i+3:4i]`, so units are bits 3:0 and ten-thousands are bits 19:16. A decade going from 9 to 0 steps the next decade.
- R4: With `mode_sel` = 2'b11, the units field reads 0. The internal units decade still counts, and the tens decade steps when the units go from 4 to 5.
- R5: With `mode_sel` = 2'b10, the units field reads 5 while the internal units value is 3 to 7, and reads 0 for 8, 9, 0, 1 and 2. The tens decade steps when the units go from 7 to 8.
- R6: With `mode_sel` = 2'b01 (test), the units field reads 0. Every count event steps the units, tens and thousands decades directly. Hundreds step on a tens 9-to-0, and ten-thousands step on a thousands 9-to-0.
- R7: In the modes that blank the units field, the units decade keeps counting. Returning to 2'b00 shows its value at once.
- R8: `carry_out` goes high from the cycle after a count event in which the top decade rolls from 9 to 0. It falls at the next count event that does not roll the top decade.
- R9: `master_clr` (active high) clears all decades at the next clock edge and overrides a count event in the same cycle. `carry_out` is high combinationally while `master_clr` is high, and it is 0 after release until a new roll-over.
- R10: Every digit field always holds a value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_in | input | 1 | Asynchronous event line, counted on rising transitions |
| master_clr | input | 1 | Synchronous clear of all decades, active high |
| mode_sel | input | 2 | Units-decade mode: 00 decimal, 01 test, 10 half-unit, 11 round-off |
| digit_out | output | 20 | Five BCD digits, units in bits 3:0 |
| carry_out | output | 1 | Top-decade roll-over flag, also high during master clear |

## Verification
The bound assertions check these properties on every cycle:
- Every digit stays in range.
- The count strobe is single-cycle.
- The decades stay still without a strobe.
- The units step by one on each strobe.
- A decade reads zero after it wraps.
- The clear empties the counter.
- The units field is blanked or limited to 5 and 0 as the mode demands.
- A rising `carry_out` always follows a strobe.

Some behaviours only the bench scenarios can show:
- Where each carry comes from in each mode.
- The hidden units value that appears when the mode returns to decimal.
- The exact cycle in which the top decade rolls over.
- That a held high level counts only once.

// File: rtl/bcd_evt_pkg.sv
package bcd_evt_pkg;

  localparam int DIGIT_W = 4;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum logic [1:0] {
    MODE_DECIMAL = 2'b00,
    MODE_TEST    = 2'b01,
    MODE_HALF    = 2'b10,
    MODE_ROUND   = 2'b11
  } cnt_mode_e;

  // next decimal value of a single digit
  function automatic digit_t digit_next(digit_t d);
    return (d == digit_t'(9)) ? digit_t'(0) : d + digit_t'(1);
  endfunction

  // units value at which the units decade hands a carry to the tens decade
  function automatic logic front_carry(cnt_mode_e m, digit_t d);
    case (m)
      MODE_ROUND: return d == digit_t'(4);
      MODE_HALF:  return d == digit_t'(7);
      default:    return d == digit_t'(9);
    endcase
  endfunction

  // value shown in the units field for each mode
  function automatic digit_t front_show(cnt_mode_e m, digit_t d);
    case (m)
      MODE_DECIMAL: return d;
      MODE_HALF:    return (d >= digit_t'(3) && d <= digit_t'(7)) ? digit_t'(5) : digit_t'(0);
      default:      return digit_t'(0);
    endcase
  endfunction

  // decades stepped straight from the event strobe in test mode
  function automatic bit test_direct(int idx);
    return (idx == 0) || ((idx % 2) == 1);
  endfunction

endpackage

// File: rtl/bcd_evt_edge.sv
module bcd_evt_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic pulse
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pulse = sync_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/bcd_evt_decade.sv
module bcd_evt_decade
  import bcd_evt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   step,
  output digit_t value,
  output logic   wrap
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (clr)  value <= '0;
    else if (step) value <= digit_next(value);
  end

  assign wrap = step & ~clr & (value == digit_t'(9));

endmodule

// File: rtl/bcd_evt_route.sv
module bcd_evt_route
  import bcd_evt_pkg::*;
#(
  parameter int NUM_DECADES = 5
) (
  input  cnt_mode_e              mode,
  input  logic                   cnt_en,
  input  digit_t                 units,
  input  logic [NUM_DECADES-1:0] wrap,
  output logic [NUM_DECADES-1:0] step
);

  logic test_on;
  assign test_on = (mode == MODE_TEST);

  for (genvar i = 0; i < NUM_DECADES; i++) begin : g_rt
    if (i == 0) begin : g_units
      assign step[i] = cnt_en;
    end else if (i == 1) begin : g_tens
      assign step[i] = test_on ? cnt_en : (cnt_en & front_carry(mode, units));
    end else if (test_direct(i)) begin : g_direct
      assign step[i] = test_on ? cnt_en : wrap[i-1];
    end else begin : g_chain
      assign step[i] = wrap[i-1];
    end
  end

endmodule

// File: rtl/bcd_evt_counter.sv
module bcd_evt_counter
  import bcd_evt_pkg::*;
#(
  parameter  int NUM_DECADES = 5,
  parameter  int SYNC_STAGES = 2,
  localparam int OUT_W       = NUM_DECADES * DIGIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_in,
  input  logic             master_clr,
  input  logic [1:0]       mode_sel,
  output logic [OUT_W-1:0] digit_out,
  output logic             carry_out
);

  cnt_mode_e              mode;
  logic                   cnt_en;
  logic [NUM_DECADES-1:0] step;
  logic [NUM_DECADES-1:0] wrap;
  digit_t                 dec_val [NUM_DECADES];
  logic [OUT_W-1:0]       dec_raw;
  logic                   top_wrap;
  logic                   cout_q;

  assign mode = cnt_mode_e'(mode_sel);

  bcd_evt_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_in (count_in),
    .pulse  (cnt_en)
  );

  bcd_evt_route #(.NUM_DECADES(NUM_DECADES)) u_route (
    .mode   (mode),
    .cnt_en (cnt_en),
    .units  (dec_val[0]),
    .wrap   (wrap),
    .step   (step)
  );

  for (genvar i = 0; i < NUM_DECADES; i++) begin : g_dec
    bcd_evt_decade u_decade (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (master_clr),
      .step  (step[i]),
      .value (dec_val[i]),
      .wrap  (wrap[i])
    );
    assign dec_raw[i*DIGIT_W +: DIGIT_W] = dec_val[i];
    if (i == 0) begin : g_front
      assign digit_out[i*DIGIT_W +: DIGIT_W] = front_show(mode, dec_val[i]);
    end else begin : g_plain
      assign digit_out[i*DIGIT_W +: DIGIT_W] = dec_val[i];
    end
  end

  assign top_wrap = wrap[NUM_DECADES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cout_q <= 1'b0;
    else if (master_clr) cout_q <= 1'b0;
    else if (cnt_en)     cout_q <= top_wrap;
  end

  assign carry_out = master_clr | cout_q;

endmodule

// File: rtl/bcd_evt_checker.sv
module bcd_evt_checker
  import bcd_evt_pkg::*;
#(
  parameter  int NUM_DECADES = 5,
  localparam int OUT_W       = NUM_DECADES * DIGIT_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   master_clr,
  input logic [1:0]             mode_sel,
  input logic                   cnt_en,
  input logic [NUM_DECADES-1:0] wrap,
  input logic [OUT_W-1:0]       dec_raw,
  input logic [OUT_W-1:0]       digit_out,
  input logic                   carry_out
);

  for (genvar i = 0; i < NUM_DECADES; i++) begin : g_chk
    p_digit_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      digit_out[i*DIGIT_W +: DIGIT_W] <= 4'd9 && dec_raw[i*DIGIT_W +: DIGIT_W] <= 4'd9);
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[i] |=> dec_raw[i*DIGIT_W +: DIGIT_W] == '0);
  end

  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> !cnt_en);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !master_clr) |=> $stable(dec_raw));

  p_units_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !master_clr) |=> dec_raw[DIGIT_W-1:0] == digit_next($past(dec_raw[DIGIT_W-1:0])));

  p_blank_round_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |-> digit_out[DIGIT_W-1:0] == '0);

  p_half_show_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10) |-> (digit_out[DIGIT_W-1:0] == 4'd0 || digit_out[DIGIT_W-1:0] == 4'd5));

  p_blank_test_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01) |-> digit_out[DIGIT_W-1:0] == '0);

  p_cout_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(carry_out) && !master_clr) |-> $past(cnt_en));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    master_clr |=> dec_raw == '0);

  p_cout_in_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    master_clr |-> carry_out);

endmodule

bind bcd_evt_counter bcd_evt_checker #(.NUM_DECADES(NUM_DECADES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .master_clr (master_clr),
  .mode_sel   (mode_sel),
  .cnt_en     (cnt_en),
  .wrap       (wrap),
  .dec_raw    (dec_raw),
  .digit_out  (digit_out),
  .carry_out  (carry_out)
);

// File: tb/tb_bcd_evt_counter.sv
`timescale 1ns/100ps
module tb_bcd_evt_counter;

  localparam int ND = 5;
  localparam int W  = ND * 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         count_in = 1'b0;
  logic         master_clr = 1'b0;
  logic [1:0]   mode_sel = 2'b00;
  logic [W-1:0] digit_out;
  logic         carry_out;

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";

  // behavioural reference state
  int d [ND];
  bit s1, s2, prv, cout_m;

  always #2.5 clk = ~clk;

  bcd_evt_counter dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_in   (count_in),
    .master_clr (master_clr),
    .mode_sel   (mode_sel),
    .digit_out  (digit_out),
    .carry_out  (carry_out)
  );

  task automatic model_event();
    bit adv [ND];
    bit top;
    if (mode_sel == 2'b01) begin
      adv[0] = 1; adv[1] = 1; adv[3] = 1;
      adv[2] = (d[1] == 9);
      adv[4] = (d[3] == 9);
    end else begin
      adv[0] = 1;
      case (mode_sel)
        2'b00: adv[1] = (d[0] == 9);
        2'b11: adv[1] = (d[0] == 4);
        default: adv[1] = (d[0] == 7);
      endcase
      for (int k = 2; k < ND; k++) adv[k] = adv[k-1] && (d[k-1] == 9);
    end
    top = adv[ND-1] && (d[ND-1] == 9);
    for (int k = 0; k < ND; k++) if (adv[k]) d[k] = (d[k] + 1) % 10;
    cout_m = top;
  endtask

  always @(posedge clk) begin
    bit en;
    if (!rst_n) begin
      for (int k = 0; k < ND; k++) d[k] = 0;
      s1 = 0; s2 = 0; prv = 0; cout_m = 0;
    end else begin
      en = s2 && !prv;
      prv = s2; s2 = s1; s1 = count_in;
      if (master_clr) begin
        for (int k = 0; k < ND; k++) d[k] = 0;
        cout_m = 0;
      end else if (en) begin
        model_event();
      end
    end
  end

  function automatic logic [W-1:0] expected_digits();
    logic [W-1:0] e;
    int u;
    for (int k = 1; k < ND; k++) e[k*4 +: 4] = 4'(d[k]);
    case (mode_sel)
      2'b00: u = d[0];
      2'b10: u = (d[0] >= 3 && d[0] <= 7) ? 5 : 0;
      default: u = 0;
    endcase
    e[3:0] = 4'(u);
    return e;
  endfunction

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    logic [W-1:0] ed;
    logic         ec;
    ed = rst_n ? expected_digits() : '0;
    ec = rst_n ? (master_clr | cout_m) : 1'b0;
    vectors++;
    if (digit_out !== ed || carry_out !== ec) begin
      miscompares++;
      $display("FAIL %s: digits=%h carry=%b expected digits=%h carry=%b",
               cur_req, digit_out, carry_out, ed, ec);
    end
    for (int k = 0; k < ND; k++) begin
      if (digit_out[k*4 +: 4] > 4'd9) begin
        miscompares++;
        $display("FAIL R10: digit %0d=%h expected 0..9", k, digit_out[k*4 +: 4]);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic events(int n);
    for (int k = 0; k < n; k++) begin
      count_in = 1'b1; tick(3);
      count_in = 1'b0; tick(3);
    end
  endtask

  task automatic check(string req, logic [W-1:0] exp_d, logic exp_c);
    vectors++;
    if (digit_out !== exp_d || carry_out !== exp_c) begin
      miscompares++;
      $display("FAIL %s: digits=%h carry=%b expected digits=%h carry=%b",
               req, digit_out, carry_out, exp_d, exp_c);
    end
  endtask

  task automatic clear_all();
    master_clr = 1'b1; tick(2);
    master_clr = 1'b0; tick(1);
  endtask

  initial begin
    tick(4);
    check("R1", 20'h00000, 1'b0);
    rst_n = 1'b1;
    tick(2);
    check("R1", 20'h00000, 1'b0);

    cur_req = "R3";
    events(23);
    check("R3", 20'h00023, 1'b0);

    cur_req = "R2";
    count_in = 1'b1; tick(20);
    count_in = 1'b0; tick(4);
    check("R2", 20'h00024, 1'b0);

    cur_req = "R9";
    count_in = 1'b1; tick(2);
    master_clr = 1'b1; tick(1);
    check("R9", 20'h00000, 1'b1);
    tick(2);
    master_clr = 1'b0; count_in = 1'b0; tick(2);
    check("R9", 20'h00000, 1'b0);

    cur_req = "R4";
    mode_sel = 2'b11;
    events(12);
    check("R4", 20'h00010, 1'b0);

    cur_req = "R7";
    mode_sel = 2'b00; tick(1);
    check("R7", 20'h00012, 1'b0);

    clear_all();
    cur_req = "R5";
    mode_sel = 2'b10;
    events(4);
    check("R5", 20'h00005, 1'b0);
    events(14);
    check("R5", 20'h00020, 1'b0);

    clear_all();
    cur_req = "R6";
    mode_sel = 2'b01;
    events(37);
    check("R6", 20'h37370, 1'b0);

    clear_all();
    cur_req = "R8";
    events(99);
    check("R6", 20'h99990, 1'b0);
    mode_sel = 2'b00; tick(1);
    check("R7", 20'h99999, 1'b0);
    events(1);
    check("R8", 20'h00000, 1'b1);
    events(1);
    check("R8", 20'h00001, 1'b0);

    clear_all();
    mode_sel = 2'b01;
    events(100);
    check("R8", 20'h00000, 1'b1);
    mode_sel = 2'b00;
    events(1);
    check("R8", 20'h00001, 1'b0);

    tick(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, expected end within 60000 cycles");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule